// File: doc/BRIEF.md
# Tagged Memory Access Checker

This block sits next to a load/store path and checks each access against a small tag store. The modelled memory is split into 16-byte granules, and each granule holds a 4-bit lock tag. Every 64-bit address carries a 4-bit key in its top byte, and that byte takes no part in forming the granule index. Both reads and writes are checked. When the key equals the granule's tag, the access is granted. When they differ, the block reacts according to the mode chosen for that access.

In precise mode, a mismatching access is refused and flagged in its own response. The first such address is also captured for later inspection. In deferred mode, the access goes ahead, and the mismatch only sets a sticky flag and increments a saturating counter. This mode records that a fault happened but not which access caused it. A separate tag-write port assigns one granule tag per cycle. A clear input empties all fault records.

Only 16 tag values exist, so an access that lands on the wrong granule is still granted when that granule's tag happens to equal the key. This is correct behaviour, not a defect.

Top module: `tag_guard`

## Requirements
- R1: After reset, every granule tag is 0, and `rsp_valid`, `async_sticky`, `async_count` and `fault_addr_valid` are 0.
- R2: The key is address bits [59:56]. The granule index is bits [9:4] (64 granules by default). Bits [3:0] select a byte within the granule. Bits [63:60] and [55:10] do not affect the result, so addresses alias modulo the modelled region.
- R3: A tag write stores `twr_tag` into granule `twr_index` at the clock edge. An access in the same cycle to that granule is checked against the previous tag.
- R4: Every request, read or write, produces a response on the cycle after it is sampled. `rsp_is_write` echoes the request's kind. A matching key gives `rsp_grant`=1 and `rsp_fault`=0. Without a request, `rsp_valid` is 0.
- R5: In precise mode (`mode_deferred`=0), a mismatch gives `rsp_grant`=0 and `rsp_fault`=1.
- R6: The first precise-mode mismatch after reset or clear latches the full 64-bit address into `fault_addr` and sets `fault_addr_valid`. Later mismatches do not overwrite it.
- R7: In deferred mode, a mismatch still gives `rsp_grant`=1 and `rsp_fault`=0, and it sets `async_sticky`. The flag holds until cleared.
- R8: Each deferred-mode mismatch increments `async_count`, which saturates at 2^CNT_W-1 (15 by default).
- R9: `clear_faults` zeroes `async_sticky`, `async_count` and `fault_addr_valid`. It takes precedence over a fault sampled in the same cycle.
- R10: An access whose key equals the tag of the granule it actually reaches is granted, even when that granule belongs to another object.
- R11: The mode is sampled with each request. Deferred mismatches never latch `fault_addr`, and precise mismatches never change the counter or the sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_deferred | input | 1 | 0 = precise fault mode, 1 = deferred fault mode, sampled with the request |
| req_valid | input | 1 | Access request present |
| req_addr | input | 64 | Tagged access address |
| req_write | input | 1 | 1 = store, 0 = load |
| twr_valid | input | 1 | Tag write enable |
| twr_index | input | 6 | Granule to retag |
| twr_tag | input | 4 | New tag value |
| clear_faults | input | 1 | Clear sticky flag, counter and latched address |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Precise fault, access blocked |
| rsp_is_write | output | 1 | Echo of the request kind |
| fault_addr | output | 64 | First faulting address in precise mode |
| fault_addr_valid | output | 1 | `fault_addr` holds a captured address |
| async_sticky | output | 1 | A deferred mismatch has occurred |
| async_count | output | 4 | Saturating count of deferred mismatches |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each sampled edge. They also assume that `twr_index` always names an existing granule, which the parameters guarantee by sizing the index to the number of granules. The stimulus changes inputs only at the falling edge, and it pulses `clear_faults` only in chosen cycles, so the hold properties on the sticky flag and the latched address can be observed across long runs. Granule tags are programmed with a known pattern before the mismatch cases, and addresses are built so that only the chosen key and index bits differ between cases.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;

   typedef enum logic {
      CHK_PRECISE  = 1'b0,
      CHK_DEFERRED = 1'b1
   } chk_mode_e;

   typedef struct packed {
      logic valid;
      logic grant;
      logic fault;
      logic is_write;
   } chk_rsp_t;

endpackage

// File: rtl/tg_addr_split.sv
module tg_addr_split #(
   parameter int ADDR_W  = 64,
   parameter int KEY_LSB = 56,
   parameter int TAG_W   = 4,
   parameter int OFF_W   = 4,
   parameter int IDX_W   = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  key,
   output logic [IDX_W-1:0]  index
);

   if (KEY_LSB + TAG_W >= ADDR_W) begin : g_bad_key
      $error("key field must leave spare top bits");
   end
   if (OFF_W + IDX_W > KEY_LSB) begin : g_bad_idx
      $error("granule index overlaps key byte");
   end

   assign key   = addr[KEY_LSB +: TAG_W];
   assign index = addr[OFF_W +: IDX_W];

   logic [ADDR_W-TAG_W-IDX_W-1:0] unused_addr_bits;
   assign unused_addr_bits = {addr[ADDR_W-1:KEY_LSB+TAG_W],
                              addr[KEY_LSB-1:OFF_W+IDX_W],
                              addr[OFF_W-1:0]};

endmodule

// File: rtl/tg_tag_store.sv
module tg_tag_store #(
   parameter int TAG_W    = 4,
   parameter int NUM_GRAN = 64,
   localparam int IDX_W   = $clog2(NUM_GRAN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag
);

   if ((1 << IDX_W) != NUM_GRAN) begin : g_bad_depth
      $error("granule count must be a power of two");
   end

   logic [TAG_W-1:0] tags [NUM_GRAN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NUM_GRAN; g++) tags[g] <= '0;
      end else if (wr_en) begin
         tags[wr_idx] <= wr_tag;
      end
   end

   assign rd_tag = tags[rd_idx];

   AST_TAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> tags[$past(wr_idx)] == $past(wr_tag)); // R3

endmodule

// File: rtl/tg_fault_track.sv
module tg_fault_track
   import tag_guard_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int CNT_W        = 4,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chk_mode_e         mode,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              mismatch,
   input  logic              clear,
   output chk_rsp_t          rsp,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              fault_addr_valid,
   output logic              sticky,
   output logic [CNT_W-1:0]  count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("counter width must be positive");
   end

   logic precise_hit, deferred_hit;
   assign precise_hit  = req_valid && mismatch && (mode == CHK_PRECISE);
   assign deferred_hit = req_valid && mismatch && (mode == CHK_DEFERRED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp <= '0;
      end else begin
         rsp.valid    <= req_valid;
         rsp.grant    <= req_valid && !precise_hit;
         rsp.fault    <= precise_hit;
         rsp.is_write <= req_valid && req_write;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_addr       <= '0;
         fault_addr_valid <= 1'b0;
      end else if (clear) begin
         fault_addr_valid <= 1'b0;
      end else if (precise_hit && !fault_addr_valid) begin
         fault_addr       <= req_addr;
         fault_addr_valid <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sticky <= 1'b0;
      else if (clear)        sticky <= 1'b0;
      else if (deferred_hit) sticky <= 1'b1;
   end

   if (CNT_SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               count <= '0;
         else if (clear)                           count <= '0;
         else if (deferred_hit && count != CNT_MAX) count <= count + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            count <= '0;
         else if (clear)        count <= '0;
         else if (deferred_hit) count <= count + 1'b1;
      end
   end

   AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fault_addr_valid && !clear |=> fault_addr_valid && $stable(fault_addr)); // R6
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sticky && !clear |=> sticky); // R7
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !sticky && count == '0 && !fault_addr_valid); // R9
   if (CNT_SATURATE) begin : g_sat_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         count == CNT_MAX && !clear |=> count == CNT_MAX); // R8
   end

endmodule

// File: rtl/tag_guard.sv
module tag_guard
   import tag_guard_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int KEY_LSB    = 56,
   parameter int TAG_W      = 4,
   parameter int GRAN_BYTES = 16,
   parameter int NUM_GRAN   = 64,
   parameter int CNT_W      = 4,
   localparam int OFF_W     = $clog2(GRAN_BYTES),
   localparam int IDX_W     = $clog2(NUM_GRAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_deferred,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              twr_valid,
   input  logic [IDX_W-1:0]  twr_index,
   input  logic [TAG_W-1:0]  twr_tag,
   input  logic              clear_faults,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_fault,
   output logic              rsp_is_write,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              fault_addr_valid,
   output logic              async_sticky,
   output logic [CNT_W-1:0]  async_count
);

   if ((1 << OFF_W) != GRAN_BYTES) begin : g_bad_gran
      $error("granule size must be a power of two");
   end

   logic [TAG_W-1:0] key, lock;
   logic [IDX_W-1:0] gran_idx;
   chk_rsp_t         rsp;
   chk_mode_e        mode;

   assign mode = chk_mode_e'(mode_deferred);

   tg_addr_split #(.ADDR_W(ADDR_W), .KEY_LSB(KEY_LSB), .TAG_W(TAG_W),
                   .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
      .addr (req_addr),
      .key  (key),
      .index(gran_idx)
   );

   tg_tag_store #(.TAG_W(TAG_W), .NUM_GRAN(NUM_GRAN)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (twr_valid),
      .wr_idx(twr_index),
      .wr_tag(twr_tag),
      .rd_idx(gran_idx),
      .rd_tag(lock)
   );

   tg_fault_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CNT_SATURATE(1'b1)) u_track (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode            (mode),
      .req_valid       (req_valid),
      .req_write       (req_write),
      .req_addr        (req_addr),
      .mismatch        (key != lock),
      .clear           (clear_faults),
      .rsp             (rsp),
      .fault_addr      (fault_addr),
      .fault_addr_valid(fault_addr_valid),
      .sticky          (async_sticky),
      .count           (async_count)
   );

   assign rsp_valid    = rsp.valid;
   assign rsp_grant    = rsp.grant;
   assign rsp_fault    = rsp.fault;
   assign rsp_is_write = rsp.is_write;

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R4
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_grant); // R4
   AST_PRECISE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !mode_deferred && key != lock |=> !rsp_grant && rsp_fault); // R5
   AST_DEFERRED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode_deferred |=> rsp_grant && !rsp_fault); // R7
   AST_DEFERRED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_addr_valid && !(req_valid && !mode_deferred) |=> !fault_addr_valid); // R11

endmodule

// File: tb/tag_guard_test.sv
module tag_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_deferred = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        twr_valid = 1'b0;
   logic [5:0]  twr_index = '0;
   logic [3:0]  twr_tag = '0;
   logic        clear_faults = 1'b0;
   logic        rsp_valid, rsp_grant, rsp_fault, rsp_is_write;
   logic [63:0] fault_addr;
   logic        fault_addr_valid, async_sticky;
   logic [3:0]  async_count;

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   tag_guard uut (
      .clk(clk), .rst_n(rst_n), .mode_deferred(mode_deferred),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .twr_valid(twr_valid), .twr_index(twr_index), .twr_tag(twr_tag),
      .clear_faults(clear_faults),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
      .rsp_is_write(rsp_is_write), .fault_addr(fault_addr),
      .fault_addr_valid(fault_addr_valid), .async_sticky(async_sticky),
      .async_count(async_count)
   );

   // {deferred, address, expected grant, expected fault}; tag of granule g = g[3:0] ^ 5
   localparam int NV = 12;
   localparam logic [66:0] VEC [NV] = '{
      {1'b0, 64'h0500_0000_0000_0000, 1'b1, 1'b0},  // R4 match granule 0
      {1'b0, 64'h0500_0000_0000_000F, 1'b1, 1'b0},  // R2 byte offset ignored
      {1'b0, 64'h0400_0000_0000_0000, 1'b0, 1'b1},  // R5 mismatch blocked
      {1'b0, 64'h0400_0000_0000_0010, 1'b1, 1'b0},  // R4 granule 1
      {1'b0, 64'h0F00_0000_0000_00A0, 1'b1, 1'b0},  // R4 granule 10
      {1'b0, 64'h0A00_0000_0000_03F5, 1'b1, 1'b0},  // R4 last granule
      {1'b0, 64'h0A00_0000_0001_03F5, 1'b1, 1'b0},  // R2 aliasing bits
      {1'b0, 64'hF700_0000_0000_0020, 1'b1, 1'b0},  // R2 top nibble ignored
      {1'b0, 64'h0700_0000_0000_0030, 1'b0, 1'b1},  // R5 mismatch granule 3
      {1'b1, 64'h0000_0000_0000_0010, 1'b1, 1'b0},  // R7 deferred mismatch passes
      {1'b1, 64'h0400_0000_0000_0010, 1'b1, 1'b0},  // R7 deferred match
      {1'b0, 64'h0600_0000_0000_0033, 1'b1, 1'b0}   // R4 granule 3 match
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic md, input logic rv, input logic [63:0] ad,
                       input logic wr, input logic tv, input logic [5:0] ti,
                       input logic [3:0] tt, input logic clr);
      @(negedge clk);
      mode_deferred = md; req_valid = rv; req_addr = ad; req_write = wr;
      twr_valid = tv; twr_index = ti; twr_tag = tt; clear_faults = clr;
      @(posedge clk);
      #1;
      req_valid = 1'b0; twr_valid = 1'b0; clear_faults = 1'b0; req_write = 1'b0;
   endtask

   task automatic access(input logic md, input logic [63:0] ad);
      step(md, 1'b1, ad, 1'b0, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic clear();
      step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 reset outputs", {60'd0, rsp_valid, async_sticky, fault_addr_valid, |async_count}, 64'd0);
      access(1'b0, 64'h0000_0000_0000_0070);
      check("R1 reset tags zero", {62'd0, rsp_grant, rsp_fault}, 64'h2);
      access(1'b0, 64'h0300_0000_0000_0070);
      check("R1 nonzero key faults", {62'd0, rsp_grant, rsp_fault}, 64'h1);
      clear();
      check("R9 clear latched addr", {63'd0, fault_addr_valid}, 64'd0);
      check("R4 idle no response", {63'd0, rsp_valid}, 64'd0);

      for (int g = 0; g < 64; g++)
         step(1'b0, 1'b0, '0, 1'b0, 1'b1, 6'(g), 4'(g) ^ 4'h5, 1'b0);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][66], VEC[i][65:2]);
         check($sformatf("R4/R5/R7 vector %0d", i),
               {61'd0, rsp_valid, rsp_grant, rsp_fault}, {61'd0, 1'b1, VEC[i][1:0]});
      end

      check("R6 first address kept", fault_addr, 64'h0400_0000_0000_0000);
      check("R6 latched valid", {63'd0, fault_addr_valid}, 64'd1);
      check("R8 R11 one deferred count", {59'd0, async_sticky, async_count}, {59'd0, 1'b1, 4'd1});

      clear();
      check("R9 clear all", {58'd0, async_sticky, fault_addr_valid, async_count}, 64'd0);

      // R3 same-cycle write sees old tag (granule 5 tag is 0)
      step(1'b0, 1'b1, 64'h0000_0000_0000_0050, 1'b0, 1'b1, 6'd5, 4'd9, 1'b0);
      check("R3 old tag used", {62'd0, rsp_grant, rsp_fault}, 64'h2);
      access(1'b0, 64'h0900_0000_0000_0050);
      check("R3 new tag active", {62'd0, rsp_grant, rsp_fault}, 64'h2);
      access(1'b0, 64'h0000_0000_0000_0058);
      check("R3 old key now faults", {62'd0, rsp_grant, rsp_fault}, 64'h1);
      check("R6 address after clear", fault_addr, 64'h0000_0000_0000_0058);

      step(1'b0, 1'b1, 64'h0400_0000_0000_0010, 1'b1, 1'b0, '0, '0, 1'b0);
      check("R4 write echoed", {61'd0, rsp_is_write, rsp_grant, rsp_fault}, 64'h6);
      access(1'b0, 64'h0400_0000_0000_0010);
      check("R4 read echoed", {63'd0, rsp_is_write}, 64'd0);

      clear();
      for (int k = 0; k < 20; k++) access(1'b1, 64'h0000_0000_0000_0010);
      check("R8 saturates", {60'd0, async_count}, 64'd15);
      check("R7 sticky set", {63'd0, async_sticky}, 64'd1);
      check("R11 deferred no latch", {63'd0, fault_addr_valid}, 64'd0);

      step(1'b1, 1'b1, 64'h0000_0000_0000_0010, 1'b0, 1'b0, '0, '0, 1'b1);
      check("R9 clear beats fault", {59'd0, async_sticky, async_count}, 64'd0);
      access(1'b1, 64'h0000_0000_0000_0010);
      check("R8 count from zero", {59'd0, async_sticky, async_count}, {59'd0, 1'b1, 4'd1});
      access(1'b0, 64'h0000_0000_0000_0010);
      check("R11 precise leaves count", {60'd0, async_count}, 64'd1);
      check("R11 precise latches", fault_addr, 64'h0000_0000_0000_0010);

      // R10 overflow from granule 0 (key 5) into granule 17 (tag 4)
      access(1'b0, 64'h0500_0000_0000_0110);
      check("R10 differing tag caught", {62'd0, rsp_grant, rsp_fault}, 64'h1);
      access(1'b0, 64'h0400_0000_0000_0110);
      check("R10 equal tag undetected", {62'd0, rsp_grant, rsp_fault}, 64'h2);

      finish_run();
   end

endmodule